// File: doc/BRIEF.md
# Power Control Mode Register

This block is the power-management control register of a small microcontroller core, together with the idle and powerdown mode control that goes with it. The core reaches it over a byte-wide register bus at one fixed special-function address. A write stores a mode byte. A read returns the current contents, and the read data bus is zero whenever this register is not being read.

The stored bits drive four control lines. Two of them go to the clock-gating logic: idle enable and powerdown enable. Powerdown always takes priority over idle. The other two go to the serial port. One doubles its baud rate. The other chooses whether bit 7 of the serial control register reaches the framing-error flag or the mode bit.

Hardware also changes the register on its own. An interrupt drops both mode bits, so the core wakes up. A one-cycle pulse from the supply monitor marks that power was lost. That power-lost flag survives an ordinary reset, so software can tell a cold start from a warm one. Two spare flags are left to software.

Top module: `pwr_ctl_reg`

## Requirements
- R1: While reset is low, bits 7, 6, 3, 2, 1 and 0 are held at 0, and so are idleEn, pdEn, baudDouble and serBit7Fe.
- R2: A write with sfrAddr equal to SELF_ADDR (0x87) stores data bits 7, 6, 4, 3, 2, 1 and 0 at the next rising edge. Reading that address returns {dbl[7], sel[6], 0[5], pof[4], gf1[3], gf0[2], pd[1], idl[0]}.
- R3: A write to any other address leaves the register unchanged. sfrRdata is 0 whenever sfrRd is low or sfrAddr is not SELF_ADDR.
- R4: pdEn equals bit 1. idleEn equals bit 0 only while bit 1 is 0, so powerdown wins when both bits are set.
- R5: An irqEvent cycle clears bits 1 and 0 at the next edge. This also holds when a write in the same cycle tries to set them.
- R6: A porDet pulse sets bit 4 at the next edge. It overrides a write in the same cycle, and a reset does not clear bit 4.
- R7: Software writes can clear bit 4 and set it again.
- R8: baudDouble follows bit 7 and serBit7Fe follows bit 6. Bit 5 always reads 0, and writing it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sfrAddr | input | 8 | Register address |
| sfrWr | input | 1 | Write strobe |
| sfrRd | input | 1 | Read strobe |
| sfrWdata | input | 8 | Write data |
| sfrRdata | output | 8 | Read data, zero when not selected |
| irqEvent | input | 1 | Interrupt wake-up event |
| porDet | input | 1 | One-cycle supply-restored pulse |
| idleEn | output | 1 | Idle request to clock gating |
| pdEn | output | 1 | Powerdown request to clock gating |
| baudDouble | output | 1 | Serial baud-rate doubling |
| serBit7Fe | output | 1 | Serial bit 7 goes to framing-error flag when high |

## Verification
The directed cases cover several distinct situations:
- A write with every bit set shows that bit 5 is dropped and that powerdown masks idle.
- An idle-only byte shows the idle path on its own.
- Writes aimed at a neighbouring address, and reads without a strobe, separate a decode fault from a storage fault.
- An interrupt in the same cycle as a write, and a supply pulse in the same cycle as a clearing write, expose the wrong priority order.

Seeded random traffic then mixes matching and foreign addresses with sparse interrupts and supply pulses. This shows whether each bit keeps its own value across long runs.

// File: rtl/pwr_ctl_pkg.sv
`timescale 1ns/1ps
package pwr_ctl_pkg;
  // Bit positions: software and the serial port decode these.
  localparam int BIT_IDL = 0;
  localparam int BIT_PD  = 1;
  localparam int BIT_GF0 = 2;
  localparam int BIT_GF1 = 3;
  localparam int BIT_POF = 4;
  localparam int BIT_RSV = 5;
  localparam int BIT_SEL = 6;
  localparam int BIT_DBL = 7;
  localparam int REG_BITS = 8;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic clrMode;
    logic setPof;
  } pwrStrobe_t;
endpackage

// File: rtl/pwr_ctl_ctrl.sv
`timescale 1ns/1ps
module pwr_ctl_ctrl
  import pwr_ctl_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] SELF_ADDR = 8'h87
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic          irq,
  input  logic          por,
  output pwrStrobe_t    strb
);
  logic hit;

  assign hit          = (addr == SELF_ADDR);
  assign strb.wrEn    = wr & hit;
  assign strb.rdEn    = rd & hit;
  assign strb.clrMode = irq;
  assign strb.setPof  = por;

  // R3: a write aimed at another address never reaches the datapath.
  a_r3_foreign_write_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (addr != SELF_ADDR) |-> !strb.wrEn && !strb.rdEn);
endmodule

// File: rtl/pwr_ctl_dp.sv
`timescale 1ns/1ps
module pwr_ctl_dp
  import pwr_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  pwrStrobe_t    strb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          idleEn,
  output logic          pdEn,
  output logic          baudDouble,
  output logic          serBit7Fe
);
  localparam int PAD = DW - REG_BITS;

  logic dbl, sel, pof, gf1, gf0, pd, idl;
  logic [REG_BITS-1:0] image;
  logic unusedRsv;

  assign unusedRsv = wdata[BIT_RSV];

  // Reset-cleared bits. An interrupt clear is applied after the write,
  // so it wins over a write in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbl <= 1'b0;
      sel <= 1'b0;
      gf1 <= 1'b0;
      gf0 <= 1'b0;
      pd  <= 1'b0;
      idl <= 1'b0;
    end else begin
      if (strb.wrEn) begin
        dbl <= wdata[BIT_DBL];
        sel <= wdata[BIT_SEL];
        gf1 <= wdata[BIT_GF1];
        gf0 <= wdata[BIT_GF0];
        pd  <= wdata[BIT_PD];
        idl <= wdata[BIT_IDL];
      end
      if (strb.clrMode) begin
        pd  <= 1'b0;
        idl <= 1'b0;
      end
    end
  end

  // The power-lost flag is outside the reset domain.
  // The hardware set beats a software write in the same cycle.
  always_ff @(posedge clk) begin
    if (strb.setPof)    pof <= 1'b1;
    else if (strb.wrEn) pof <= wdata[BIT_POF];
  end

  always_comb begin
    image          = '0;
    image[BIT_DBL] = dbl;
    image[BIT_SEL] = sel;
    image[BIT_POF] = pof;
    image[BIT_GF1] = gf1;
    image[BIT_GF0] = gf0;
    image[BIT_PD]  = pd;
    image[BIT_IDL] = idl;
  end

  generate
    if (PAD > 0) begin : g_pad
      assign rdata = strb.rdEn ? {{PAD{1'b0}}, image} : '0;
    end else begin : g_nopad
      assign rdata = strb.rdEn ? image : '0;
    end
  endgenerate

  assign pdEn       = pd;
  assign idleEn     = idl & ~pd;
  assign baudDouble = dbl;
  assign serBit7Fe  = sel;

  a_r5_irq_clears_modes: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrMode |=> !pdEn && !idleEn);
  a_r6_por_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    strb.setPof |=> pof);
  a_r4_pd_excludes_idle: assert property (@(posedge clk) disable iff (!rstN)
    pdEn |-> !idleEn);
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> (gf1 == $past(wdata[BIT_GF1])) && (gf0 == $past(wdata[BIT_GF0]))
                  && (baudDouble == $past(wdata[BIT_DBL])) && (serBit7Fe == $past(wdata[BIT_SEL])));
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrEn && !strb.clrMode) |=> $stable({dbl, sel, gf1, gf0, pd, idl}));
endmodule

// File: rtl/pwr_ctl_reg.sv
`timescale 1ns/1ps
module pwr_ctl_reg
  import pwr_ctl_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] SELF_ADDR = 8'h87
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] sfrAddr,
  input  logic          sfrWr,
  input  logic          sfrRd,
  input  logic [DW-1:0] sfrWdata,
  output logic [DW-1:0] sfrRdata,
  input  logic          irqEvent,
  input  logic          porDet,
  output logic          idleEn,
  output logic          pdEn,
  output logic          baudDouble,
  output logic          serBit7Fe
);
  pwrStrobe_t strb;

  pwr_ctl_ctrl #(.AW(AW), .SELF_ADDR(SELF_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(sfrAddr), .wr(sfrWr), .rd(sfrRd),
    .irq(irqEvent), .por(porDet), .strb(strb)
  );

  pwr_ctl_dp #(.DW(DW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(sfrWdata), .rdata(sfrRdata),
    .idleEn(idleEn), .pdEn(pdEn), .baudDouble(baudDouble), .serBit7Fe(serBit7Fe)
  );
endmodule

// File: tb/pwr_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module pwr_ctl_reg_tb_top;
  localparam logic [7:0] ADDR = 8'h87;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] sfrAddr = '0, sfrWdata = '0;
  logic [7:0] sfrRdata;
  logic sfrWr = 1'b0, sfrRd = 1'b0, irqEvent = 1'b0, porDet = 1'b0;
  logic idleEn, pdEn, baudDouble, serBit7Fe;

  int nChecks = 0;
  int nFails = 0;

  // Reference model of the register contents.
  logic mDbl, mSel, mPof, mGf1, mGf0, mPd, mIdl;

  always #5 clk = ~clk;

  pwr_ctl_reg dut_i (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWr(sfrWr), .sfrRd(sfrRd),
    .sfrWdata(sfrWdata), .sfrRdata(sfrRdata), .irqEvent(irqEvent), .porDet(porDet),
    .idleEn(idleEn), .pdEn(pdEn), .baudDouble(baudDouble), .serBit7Fe(serBit7Fe)
  );

  function automatic logic [7:0] expImage();
    return {mDbl, mSel, 1'b0, mPof, mGf1, mGf0, mPd, mIdl};
  endfunction

  function automatic logic [3:0] expPins();
    return {mIdl & ~mPd, mPd, mDbl, mSel};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // One bus cycle, then the model is advanced the same way the requirements say.
  task automatic busCycle(input bit wr, input logic [7:0] addr, input logic [7:0] data,
                          input bit irq, input bit por);
    @(negedge clk);
    sfrWr = wr; sfrRd = 1'b0; sfrAddr = addr; sfrWdata = data;
    irqEvent = irq; porDet = por;
    @(posedge clk);
    if (wr && addr == ADDR) begin
      {mDbl, mSel} = data[7:6];
      {mPof, mGf1, mGf0, mPd, mIdl} = data[4:0];
    end
    if (irq) begin mPd = 1'b0; mIdl = 1'b0; end
    if (por) mPof = 1'b1;
  endtask

  task automatic readCheck(input string tag);
    @(negedge clk);
    sfrWr = 1'b0; irqEvent = 1'b0; porDet = 1'b0; sfrRd = 1'b1; sfrAddr = ADDR;
    #1;
    chk(sfrRdata === expImage(), tag, sfrRdata, expImage());
    chk({idleEn, pdEn, baudDouble, serBit7Fe} === expPins(), {tag, " pins"},
        {4'h0, idleEn, pdEn, baudDouble, serBit7Fe}, {4'h0, expPins()});
    sfrRd = 1'b0;
  endtask

  initial begin
    #1_500_000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    // Power-up: reset held low and a supply pulse during reset.
    porDet = 1'b1;
    @(posedge clk);
    mPof = 1'b1;
    @(negedge clk); porDet = 1'b0;
    mDbl = 0; mSel = 0; mGf1 = 0; mGf0 = 0; mPd = 0; mIdl = 0;
    #1;
    chk({idleEn, pdEn, baudDouble, serBit7Fe} === 4'h0, "R1 pins in reset",
        {4'h0, idleEn, pdEn, baudDouble, serBit7Fe}, 8'h00);
    @(negedge clk); rstN = 1'b1;
    readCheck("R1 reset value");

    // R2, R4, R8: every bit set, reserved bit dropped, powerdown masks idle.
    busCycle(1, ADDR, 8'hFF, 0, 0);
    readCheck("R2 R4 R8 all ones");
    chk(idleEn === 1'b0, "R4 idle masked by pd", {7'h0, idleEn}, 8'h00);
    busCycle(1, ADDR, 8'h01, 0, 0);
    readCheck("R4 idle only");
    chk(idleEn === 1'b1, "R4 idle asserted", {7'h0, idleEn}, 8'h01);
    busCycle(1, ADDR, 8'h6C, 0, 0);
    readCheck("R8 select and flags");

    // R3: a foreign address and reads without a strobe or address match.
    busCycle(1, ADDR - 8'h1, 8'h93, 0, 0);
    readCheck("R3 foreign write ignored");
    @(negedge clk); sfrRd = 1'b0; sfrAddr = ADDR; #1;
    chk(sfrRdata === 8'h00, "R3 no read strobe", sfrRdata, 8'h00);
    sfrRd = 1'b1; sfrAddr = 8'h88; #1;
    chk(sfrRdata === 8'h00, "R3 other address read", sfrRdata, 8'h00);
    sfrRd = 1'b0;

    // R5: interrupt beats a same-cycle write, then clears stored mode bits.
    busCycle(1, ADDR, 8'h03, 1, 0);
    readCheck("R5 irq with write");
    busCycle(1, ADDR, 8'h02, 0, 0);
    busCycle(0, ADDR, 8'h00, 1, 0);
    readCheck("R5 irq clears pd");

    // R7: software clear and set of the power-lost flag.
    busCycle(1, ADDR, 8'h00, 0, 0);
    readCheck("R7 pof cleared");
    busCycle(1, ADDR, 8'h10, 0, 0);
    readCheck("R7 pof set");

    // R6: supply pulse beats a clearing write; reset keeps the flag.
    busCycle(1, ADDR, 8'h00, 0, 0);
    busCycle(1, ADDR, 8'hCD, 0, 1);
    readCheck("R6 por beats write");
    @(negedge clk); rstN = 1'b0;
    mDbl = 0; mSel = 0; mGf1 = 0; mGf0 = 0; mPd = 0; mIdl = 0;
    @(negedge clk); rstN = 1'b1;
    readCheck("R6 pof survives reset");

    // Seeded random traffic.
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = ($urandom % 2 != 0) ? ADDR : 8'($urandom);
      busCycle($urandom % 2 != 0, a, 8'($urandom), ($urandom % 8) == 0, ($urandom % 16) == 0);
      readCheck("R2 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule